// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dial Generator

This block turns decimal digits into loop-disconnect dialling on a line-control output. It accepts one digit at a time over a valid/ready handshake. For each digit it breaks the line a number of times and then holds the line made for an inter-digit pause. While it is sending, it raises a mute flag so the speech path can be silenced.

All timing is counted in ticks of an external 1 ms strobe. The block therefore works from any system clock. The rate, the make/break ratio and the pulse-count rule are read once, when a digit is accepted. A settings change made while a digit is being sent only affects the following digit.

Going on-hook breaks the line and stops any dialling at once. Tone mode and out-of-range digit codes are absorbed without any line activity.

Top module: `pulse_dialer`

## Requirements
- R1: After reset, and at any time with `off_hook` low, `line_out` is 0 and `dig_ready` is 0. Off-hook and idle, `line_out` is 1 and `dig_ready` is 1.
- R2: `rate_sel` 2'b01 selects 10 pulses/s with a 100 ms period, and 2'b10 selects 20 pulses/s with a 50 ms period. `busy` stays high for exactly count × period + pause ticks per digit.
- R3: Every pulse starts with its break (`line_out` 0) and then makes. With `ratio_sel` 1 (one-third make) the break is 67 ms at 10 pps and 33 ms at 20 pps. With `ratio_sel` 0 (40/60) the break is 60 ms and 30 ms.
- R4: Let n be the digit value, with digit 0 counted as 10. `count_sel` 2'b00 sends n pulses, 2'b01 sends n+1, and 2'b10 sends 10−n, where a result of 0 is sent as 10. 2'b11 behaves as 2'b00.
- R5: After the last pulse's make time the line stays made for 800 ms at 10 pps or 500 ms at 20 pps. `dig_ready` stays low until that pause ends.
- R6: `mute` is 1 exactly while `busy` is 1, and 0 otherwise.
- R7: Rate, ratio and count rule are captured when a digit is accepted. Changing them during a digit does not alter that digit.
- R8: In tone mode (`rate_sel` 2'b00 or 2'b11) an offered digit is taken, but `busy` stays 0 and `line_out` stays 1.
- R9: Digit codes 10 to 15 are taken and discarded, with no pulses and no `busy`.
- R10: When `off_hook` goes low, the next clock clears `busy` and `mute`. The digit in progress is abandoned and does not resume when the line goes off-hook again.
- R11: Timing advances only on clocks where `tick_1ms` is 1. Without ticks, the line level and `busy` hold.
- R12: A digit is accepted on a clock where `dig_valid` and `dig_ready` are both 1. For a pulse-mode digit 0–9, `busy` is 1 and `dig_ready` is 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_valid | input | 1 | Digit offered |
| dig_value | input | 4 | Digit code, 0–9 valid |
| dig_ready | output | 1 | Block can take a digit |
| rate_sel | input | 2 | 00/11 tone, 01 10 pps, 10 20 pps |
| ratio_sel | input | 1 | 1: one-third make, 0: 40/60 |
| count_sel | input | 2 | Pulse-count rule |
| off_hook | input | 1 | Handset off-hook |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| line_out | output | 1 | 1 = loop made, 0 = loop broken |
| mute | output | 1 | Speech mute during dialling |
| busy | output | 1 | Digit being sent |

## Verification
The hardest condition to reach from the ports is a settings change, or loss of the hook, partway through a digit. The timer is deep in a break at that point and the captured settings differ from the live inputs. The stimulus offers a digit and then waits a counted number of ticks into the break. Only then does it flip `rate_sel` or drop `off_hook`. The scoreboard then proves that the running digit kept its original timing, or that nothing resumed. A separate run holds `tick_1ms` low for hundreds of cycles mid-break and then measures that exactly the full break remains.

// File: rtl/pulse_dialer_pkg.sv
package pulse_dialer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_MAKE  = 2'd2,
        ST_GAP   = 2'd3
    } dial_state_e;

    typedef enum logic [1:0] {
        CNT_PLAIN    = 2'b00,
        CNT_PLUS_ONE = 2'b01,
        CNT_COMPL    = 2'b10,
        CNT_SPARE    = 2'b11
    } count_rule_e;

    localparam int unsigned CNT_W = 4;

    // pulses for one digit under a given rule; digit 0 counts as ten
    function automatic logic [CNT_W-1:0] pulses_for(input logic [3:0] digit,
                                                     input count_rule_e rule);
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] res;
        base = (digit == 4'd0) ? CNT_W'(10) : CNT_W'(digit);
        case (rule)
            CNT_PLUS_ONE: res = base + CNT_W'(1);
            CNT_COMPL:    res = (base == CNT_W'(10)) ? CNT_W'(10) : CNT_W'(10) - base;
            default:      res = base;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/dp_timing.sv
module dp_timing #(
    parameter int unsigned SLOW_PERIOD_MS = 100,
    parameter int unsigned FAST_PERIOD_MS = 50,
    parameter int unsigned SLOW_GAP_MS    = 800,
    parameter int unsigned FAST_GAP_MS    = 500,
    parameter int unsigned TW             = 10
) (
    input  logic          fast,
    input  logic          third_make,
    output logic [TW-1:0] brk_ms,
    output logic [TW-1:0] make_ms,
    output logic [TW-1:0] gap_ms
);
    // break shares rounded to whole ticks at elaboration time
    localparam int unsigned SLOW_BRK_THIRD = (2 * SLOW_PERIOD_MS + 1) / 3;
    localparam int unsigned FAST_BRK_THIRD = (2 * FAST_PERIOD_MS + 1) / 3;
    localparam int unsigned SLOW_BRK_FIFTH = (3 * SLOW_PERIOD_MS + 2) / 5;
    localparam int unsigned FAST_BRK_FIFTH = (3 * FAST_PERIOD_MS + 2) / 5;

    logic [TW-1:0] period;

    always_comb begin
        period = fast ? TW'(FAST_PERIOD_MS) : TW'(SLOW_PERIOD_MS);
        gap_ms = fast ? TW'(FAST_GAP_MS) : TW'(SLOW_GAP_MS);
        case ({fast, third_make})
            2'b00:   brk_ms = TW'(SLOW_BRK_FIFTH);
            2'b01:   brk_ms = TW'(SLOW_BRK_THIRD);
            2'b10:   brk_ms = TW'(FAST_BRK_FIFTH);
            default: brk_ms = TW'(FAST_BRK_THIRD);
        endcase
        make_ms = period - brk_ms;
    end
endmodule

// File: rtl/dp_digit_map.sv
module dp_digit_map
    import pulse_dialer_pkg::*;
(
    input  logic [3:0]       digit,
    input  logic [1:0]       rule_sel,
    output logic             digit_ok,
    output logic [CNT_W-1:0] pulses
);
    always_comb begin
        digit_ok = (digit <= 4'd9);
        pulses   = pulses_for(digit, count_rule_e'(rule_sel));
    end
endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
    import pulse_dialer_pkg::*;
#(
    parameter int unsigned SLOW_PERIOD_MS = 100,
    parameter int unsigned FAST_PERIOD_MS = 50,
    parameter int unsigned SLOW_GAP_MS    = 800,
    parameter int unsigned FAST_GAP_MS    = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dig_valid,
    input  logic [3:0] dig_value,
    output logic       dig_ready,
    input  logic [1:0] rate_sel,
    input  logic       ratio_sel,
    input  logic [1:0] count_sel,
    input  logic       off_hook,
    input  logic       tick_1ms,
    output logic       line_out,
    output logic       mute,
    output logic       busy
);
    localparam int unsigned MAX_A  = (SLOW_GAP_MS > FAST_GAP_MS) ? SLOW_GAP_MS : FAST_GAP_MS;
    localparam int unsigned MAX_B  = (SLOW_PERIOD_MS > FAST_PERIOD_MS) ? SLOW_PERIOD_MS : FAST_PERIOD_MS;
    localparam int unsigned MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW     = $clog2(MAX_MS + 1);

    typedef struct packed {
        dial_state_e      st;
        logic [TW-1:0]    timer;
        logic [CNT_W-1:0] left;
        logic [TW-1:0]    brk;
        logic [TW-1:0]    make;
        logic [TW-1:0]    gap;
        logic             mute;
    } dial_regs_t;

    localparam dial_regs_t REGS_RESET = '{st: ST_IDLE, timer: '0, left: '0,
                                          brk: '0, make: '0, gap: '0, mute: 1'b0};

    dial_regs_t r_d, r_q;

    logic             pulse_mode;
    logic             fast_rate;
    logic [TW-1:0]    sel_brk, sel_make, sel_gap;
    logic             digit_ok;
    logic [CNT_W-1:0] digit_pulses;
    logic             take;

    assign pulse_mode = (rate_sel == 2'b01) || (rate_sel == 2'b10);
    assign fast_rate  = (rate_sel == 2'b10);

    dp_timing #(
        .SLOW_PERIOD_MS(SLOW_PERIOD_MS),
        .FAST_PERIOD_MS(FAST_PERIOD_MS),
        .SLOW_GAP_MS   (SLOW_GAP_MS),
        .FAST_GAP_MS   (FAST_GAP_MS),
        .TW            (TW)
    ) u_timing (
        .fast      (fast_rate),
        .third_make(ratio_sel),
        .brk_ms    (sel_brk),
        .make_ms   (sel_make),
        .gap_ms    (sel_gap)
    );

    dp_digit_map u_map (
        .digit   (dig_value),
        .rule_sel(count_sel),
        .digit_ok(digit_ok),
        .pulses  (digit_pulses)
    );

    assign dig_ready = off_hook && (r_q.st == ST_IDLE);
    assign take      = dig_valid && dig_ready;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                // settings are captured here and held for the whole digit
                if (take && pulse_mode && digit_ok) begin
                    r_d.st    = ST_BREAK;
                    r_d.timer = sel_brk;
                    r_d.left  = digit_pulses;
                    r_d.brk   = sel_brk;
                    r_d.make  = sel_make;
                    r_d.gap   = sel_gap;
                end
            end
            ST_BREAK: begin
                if (tick_1ms) begin
                    if (r_q.timer == TW'(1)) begin
                        r_d.st    = ST_MAKE;
                        r_d.timer = r_q.make;
                        r_d.left  = r_q.left - CNT_W'(1);
                    end else begin
                        r_d.timer = r_q.timer - TW'(1);
                    end
                end
            end
            ST_MAKE: begin
                if (tick_1ms) begin
                    if (r_q.timer == TW'(1)) begin
                        if (r_q.left == '0) begin
                            r_d.st    = ST_GAP;
                            r_d.timer = r_q.gap;
                        end else begin
                            r_d.st    = ST_BREAK;
                            r_d.timer = r_q.brk;
                        end
                    end else begin
                        r_d.timer = r_q.timer - TW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (tick_1ms) begin
                    if (r_q.timer == TW'(1)) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.timer = r_q.timer - TW'(1);
                    end
                end
            end
            default: r_d = REGS_RESET;
        endcase
        // hanging up abandons everything
        if (!off_hook) begin
            r_d = REGS_RESET;
        end
        r_d.mute = (r_d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign mute     = r_q.mute;
    assign line_out = off_hook && (r_q.st != ST_BREAK);

endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dig_valid,
    input logic [3:0] dig_value,
    input logic       dig_ready,
    input logic [1:0] rate_sel,
    input logic       off_hook,
    input logic       tick_1ms,
    input logic       line_out,
    input logic       mute,
    input logic       busy
);
    logic tone_sel;
    assign tone_sel = (rate_sel == 2'b00) || (rate_sel == 2'b11);

    p_idle_line_made_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hook && !busy) |-> (line_out && dig_ready));

    p_onhook_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (!busy && !mute));

    p_mute_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mute);

    p_mute_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mute);

    p_no_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dig_ready);

    p_accept_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_ready && !tone_sel && dig_value <= 4'd9) |=> busy);

    p_tone_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_ready && tone_sel) |=> !busy);

    p_bad_digit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_ready && dig_value > 4'd9) |=> !busy);

    p_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && off_hook && !tick_1ms) |=> (!off_hook || ($stable(line_out) && busy)));

endmodule

bind pulse_dialer pulse_dialer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dig_valid(dig_valid),
    .dig_value(dig_value),
    .dig_ready(dig_ready),
    .rate_sel (rate_sel),
    .off_hook (off_hook),
    .tick_1ms (tick_1ms),
    .line_out (line_out),
    .mute     (mute),
    .busy     (busy)
);

// File: tb/pulse_dialer_tb.sv
`timescale 1ns/1ps
module pulse_dialer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dig_valid = 1'b0;
    logic [3:0] dig_value = 4'd0;
    logic       dig_ready;
    logic [1:0] rate_sel = 2'b01;
    logic       ratio_sel = 1'b0;
    logic [1:0] count_sel = 2'b00;
    logic       off_hook = 1'b0;
    logic       tick_1ms = 1'b1;
    logic       line_out, mute, busy;

    always #5 clk = ~clk;

    pulse_dialer u_dut (
        .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_value(dig_value),
        .dig_ready(dig_ready), .rate_sel(rate_sel), .ratio_sel(ratio_sel),
        .count_sel(count_sel), .off_hook(off_hook), .tick_1ms(tick_1ms),
        .line_out(line_out), .mute(mute), .busy(busy)
    );

    typedef struct {int cnt; int brk; int len;} exp_t;
    exp_t exp_q[$];

    int  checks = 0;
    int  errors = 0;
    bit  mon_en = 1'b0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic exp_t model(input int d);
        exp_t e;
        int period, n, gap;
        period = (rate_sel == 2'b01) ? 100 : 50;
        gap    = (rate_sel == 2'b01) ? 800 : 500;
        e.brk  = ratio_sel ? ((period == 100) ? 67 : 33) : ((period == 100) ? 60 : 30);
        n      = (d == 0) ? 10 : d;
        if (count_sel == 2'b01)      e.cnt = n + 1;
        else if (count_sel == 2'b10) e.cnt = (n == 10) ? 10 : 10 - n;
        else                         e.cnt = n;
        e.len = e.cnt * period + gap;
        return e;
    endfunction

    // driver: call at a negedge
    task automatic send(input int d, input bit expect_it);
        exp_t e;
        while (!dig_ready) @(negedge clk);
        e = model(d);
        dig_valid = 1'b1;
        dig_value = 4'(d);
        @(negedge clk);
        dig_valid = 1'b0;
        if (expect_it) begin
            exp_q.push_back(e);
            chk(busy === 1'b1 && dig_ready === 1'b0, "R12", int'(busy), 1);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic quiet(input string req, input int cycles);
        bit bad = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if (busy !== 1'b0 || line_out !== 1'b1 || mute !== 1'b0) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, req, int'(bad), 0);
    endtask

    // monitor: measure each digit and compare with the scoreboard
    bit in_dig = 1'b0;
    int len_c, nlow, run, mn, mx;
    bit mute_bad;
    always @(negedge clk) begin
        exp_t e;
        if (!mon_en) begin
            in_dig = 1'b0;
        end else if (busy === 1'b1) begin
            if (!in_dig) begin
                in_dig = 1'b1; len_c = 0; nlow = 0; run = 0;
                mn = 1000000; mx = 0; mute_bad = 1'b0;
            end
            len_c++;
            if (mute !== 1'b1) mute_bad = 1'b1;
            if (line_out === 1'b0) run++;
            else if (run > 0) begin
                nlow++;
                if (run < mn) mn = run;
                if (run > mx) mx = run;
                run = 0;
            end
        end else if (in_dig) begin
            in_dig = 1'b0;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected digit", len_c, 0);
            end else begin
                e = exp_q.pop_front();
                chk(nlow == e.cnt, "R4 pulse count", nlow, e.cnt);
                chk(mn == e.brk && mx == e.brk, "R3 break length", mn, e.brk);
                chk(len_c == e.len, "R2 R5 digit duration", len_c, e.len);
                chk(!mute_bad && mute === 1'b0, "R6 mute", int'(mute_bad), 0);
            end
        end
    end

    initial begin
        int lowc;
        repeat (3) @(negedge clk);
        // R1 on-hook after reset
        chk(line_out === 1'b0 && dig_ready === 1'b0, "R1 on-hook", int'(line_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mute === 1'b0, "R1 reset idle", int'(busy), 0);
        off_hook = 1'b1;
        @(negedge clk);
        chk(line_out === 1'b1 && dig_ready === 1'b1, "R1 off-hook idle", int'(line_out), 1);
        mon_en = 1'b1;

        // 10 pps, 40/60, plain count
        rate_sel = 2'b01; ratio_sel = 1'b0; count_sel = 2'b00;
        send(3, 1); wait_idle();
        send(0, 1); wait_idle();
        // 20 pps, one-third make, n+1
        rate_sel = 2'b10; ratio_sel = 1'b1; count_sel = 2'b01;
        send(7, 1); wait_idle();
        send(0, 1); wait_idle();
        // 10 pps, one-third make, 10-n
        rate_sel = 2'b01; ratio_sel = 1'b1; count_sel = 2'b10;
        send(0, 1); wait_idle();
        send(9, 1); wait_idle();
        send(4, 1); wait_idle();
        // spare rule code behaves as plain, 20 pps 40/60
        rate_sel = 2'b10; ratio_sel = 1'b0; count_sel = 2'b11;
        send(2, 1); wait_idle();

        // R7 settings change mid-digit
        rate_sel = 2'b01; ratio_sel = 1'b0; count_sel = 2'b00;
        send(5, 1);
        repeat (120) @(negedge clk);
        rate_sel = 2'b10; ratio_sel = 1'b1; count_sel = 2'b01;
        send(2, 1); wait_idle();
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        // R8 tone mode
        rate_sel = 2'b00;
        send(5, 0);
        quiet("R8 tone 00", 200);
        rate_sel = 2'b11;
        send(1, 0);
        quiet("R8 tone 11", 200);

        // R9 out-of-range codes
        rate_sel = 2'b01; ratio_sel = 1'b0; count_sel = 2'b00;
        send(12, 0);
        quiet("R9 code 12", 200);
        send(15, 0);
        quiet("R9 code 15", 200);

        // R10 on-hook abort
        mon_en = 1'b0;
        send(8, 0);
        repeat (30) @(negedge clk);
        chk(line_out === 1'b0, "R3 mid-break line", int'(line_out), 0);
        off_hook = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mute === 1'b0, "R10 abort clears", int'(busy), 0);
        chk(line_out === 1'b0, "R10 line broken", int'(line_out), 0);
        off_hook = 1'b1;
        @(negedge clk);
        chk(dig_ready === 1'b1, "R10 ready again", int'(dig_ready), 1);
        quiet("R10 no resume", 300);

        // R11 no ticks, no progress
        tick_1ms = 1'b0;
        send(1, 0);
        repeat (300) @(negedge clk);
        chk(line_out === 1'b0 && busy === 1'b1, "R11 frozen break", int'(line_out), 0);
        tick_1ms = 1'b1;
        lowc = 0;
        while (line_out === 1'b0 && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        chk(lowc == 60, "R11 remaining break", lowc, 60);
        wait_idle();
        chk(busy === 1'b0 && line_out === 1'b1, "R5 idle after pause", int'(busy), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule